// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. The line input passes through a two-flop synchronizer. All bit timing counts a one-cycle receive tick enable, `rx_tick`, which the surrounding logic pulses at 1, 16 or 64 times the bit rate. The tick enable lets the receiver run on the system clock and avoids a separate receive clock domain.

A falling edge on the synchronized line starts a frame. At factors 16 and 64 the line is checked again at the middle of the start bit, and a pulse that is already high again at that point is discarded. After the start bit, each later bit is sampled one full bit time after the previous sample. The data bits arrive least significant bit first, followed by an optional parity bit and then one stop bit. The finished character is held in a register with a ready flag that a read strobe clears.

Parity, overrun and framing errors are kept as sticky flags, which only the error-clear input resets. A frame that is low from start to stop sets a break indication. That indication stays up until the line goes high again.

Top module: `uart_rx_ovs`

## Requirements
- R1: `cfg_factor` selects ticks per bit: 2'b10 gives 16, 2'b11 gives 64, and 2'b01 or 2'b00 gives 1. At 16 and 64 the synchronized line is checked again half a bit (8 or 32 ticks) after the falling edge. If the line is high there, the start is rejected and the receiver returns to idle without producing a character.
- R2: After an accepted start, each data, parity and stop bit is sampled exactly one bit time (1, 16 or 64 ticks) after the previous sample. At factor 1 the start is accepted on the edge tick, and the first data bit is sampled on the next tick.
- R3: `cfg_len` gives the data bit count as 5 + `cfg_len` (0 gives 5 bits, 3 gives 8 bits). Bits arrive LSB first. `rx_data` holds them right-justified, with the unused upper bits at zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` = 1 selects even parity and 0 selects odd parity. On a mismatch, `err_parity` is set when the character completes.
- R5: A low stop-bit sample sets `err_frame`. Only the first stop bit is checked, and the receiver then looks for a new start edge at once.
- R6: If a character completes while `rx_ready` is still set and no read strobe occurs in that cycle, `err_overrun` is set and `rx_data` takes the new character.
- R7: After reset, `rx_ready`, all error flags, `brk_det` and `rx_data` are zero. `rx_ready` rises in the cycle after the stop sample. A one-cycle `rd_stb` clears it on the next edge, unless a new character completes in that same cycle, in which case the flag stays set.
- R8: A frame whose start, data, parity and stop samples are all low sets `brk_det` and `err_frame`. It leaves `rx_data`, `rx_ready`, `err_parity` and `err_overrun` unchanged. `brk_det` clears on the first cycle the synchronized line is high.
- R9: `err_parity`, `err_overrun` and `err_frame` stay set until an `err_clr` pulse clears them. If a new error occurs in the same cycle as `err_clr`, the flag stays set.
- R10: While `rx_en` is low the receiver stays idle. Dropping `rx_en` in the middle of a frame abandons that frame, and no character is produced from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_tick | input | 1 | One-cycle receive sampling enable |
| rx_en | input | 1 | Receiver enable |
| cfg_factor | input | 2 | Ticks per bit select |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rxd | input | 1 | Serial line, idle high |
| rd_stb | input | 1 | Character read strobe |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Received character, right-justified |
| rx_ready | output | 1 | Character available |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |
| brk_det | output | 1 | Break detected |

## Verification
The assertions assume that `rd_stb` and `err_clr` are single-cycle pulses. They also assume that the frame settings stay constant from the start edge to the stop sample, because the bit count and the parity check are read live while a frame is in flight. The stimulus meets these assumptions. It changes the settings only while the line has been idle for at least two bit times. It sends every strobe as a one-cycle pulse between frames. It also pulses `rx_tick` on every second clock, so each bit lasts an exact number of ticks, and the line changes well away from the sampling points.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CNT_W  = 7;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  // ticks in one bit for a factor code
  function automatic logic [CNT_W-1:0] bit_ticks(input logic [1:0] f);
    case (f)
      2'b10:   return 7'd16;
      2'b11:   return 7'd64;
      default: return 7'd1;
    endcase
  endfunction

  // ticks from start edge to start-bit midpoint (0 = no recheck)
  function automatic logic [CNT_W-1:0] half_ticks(input logic [1:0] f);
    return bit_ticks(f) >> 1;
  endfunction

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // shift register fills from the top; move the char down to bit 0
  function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sr,
                                                   input logic [1:0] len);
    return sr >> (4'd8 - data_bits(len));
  endfunction

  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic pbit, input logic even);
    logic t;
    t = (^d) ^ pbit;
    return even ? t : ~t;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= din;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_seq.sv
module uart_rx_seq
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              rxs,
  input  logic [1:0]        cfg_factor,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  output logic              done,
  output logic              brk_frame,
  output logic              busy,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_perr,
  output logic              frame_ferr
);
  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        bidx;
  logic [DATA_W-1:0] shreg;
  logic              prev_lvl;
  logic              all_low;
  logic              pbit;
  logic              at_sample;

  assign at_sample = tick && (cnt == 7'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      prev_lvl <= 1'b1;
      all_low  <= 1'b0;
      pbit     <= 1'b0;
    end else begin
      if (tick) prev_lvl <= rxs;
      if (!rx_en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        case (state)
          RX_IDLE: if (prev_lvl && !rxs) begin
            all_low <= 1'b1;
            bidx    <= '0;
            if (half_ticks(cfg_factor) == '0) begin
              state <= RX_DATA;
              cnt   <= bit_ticks(cfg_factor);
            end else begin
              state <= RX_START;
              cnt   <= half_ticks(cfg_factor);
            end
          end
          RX_START: if (at_sample) begin
            if (rxs) state <= RX_IDLE;
            else begin
              state <= RX_DATA;
              cnt   <= bit_ticks(cfg_factor);
            end
          end else cnt <= cnt - 7'd1;
          RX_DATA: if (at_sample) begin
            shreg   <= {rxs, shreg[DATA_W-1:1]};
            all_low <= all_low & ~rxs;
            cnt     <= bit_ticks(cfg_factor);
            if (bidx == data_bits(cfg_len) - 4'd1)
              state <= cfg_par_en ? RX_PAR : RX_STOP;
            else
              bidx <= bidx + 4'd1;
          end else cnt <= cnt - 7'd1;
          RX_PAR: if (at_sample) begin
            pbit    <= rxs;
            all_low <= all_low & ~rxs;
            cnt     <= bit_ticks(cfg_factor);
            state   <= RX_STOP;
          end else cnt <= cnt - 7'd1;
          RX_STOP: if (at_sample) state <= RX_IDLE;
                   else cnt <= cnt - 7'd1;
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy       = (state != RX_IDLE);
  assign done       = rx_en && (state == RX_STOP) && at_sample;
  assign brk_frame  = all_low && !rxs;
  assign frame_data = align_data(shreg, cfg_len);
  assign frame_perr = cfg_par_en && parity_bad(frame_data, pbit, cfg_par_even);
  assign frame_ferr = !rxs;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              brk_frame,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_perr,
  input  logic              frame_ferr,
  input  logic              rxs,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              brk_det
);
  logic good_char;
  assign good_char = done && !brk_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      brk_det     <= 1'b0;
    end else begin
      if (good_char) rx_data <= frame_data;
      rx_ready    <= good_char | (rx_ready & ~rd_stb);
      err_parity  <= (err_parity & ~err_clr) | (good_char & frame_perr);
      err_frame   <= (err_frame & ~err_clr) | (done & frame_ferr);
      err_overrun <= (err_overrun & ~err_clr) | (good_char & rx_ready & ~rd_stb);
      brk_det     <= (done & brk_frame) | (brk_det & ~rxs);
    end
  end
endmodule

// File: rtl/uart_rx_ovs.sv
module uart_rx_ovs
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_tick,
  input  logic              rx_en,
  input  logic [1:0]        cfg_factor,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              rxd,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              brk_det
);
  // named internal events, also used by the bound checker
  logic              rxs;
  logic              char_done;
  logic              brk_frame;
  logic              busy;
  logic [DATA_W-1:0] frame_data;
  logic              frame_perr;
  logic              frame_ferr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxs)
  );

  uart_rx_seq u_seq (
    .clk(clk), .rst(rst), .tick(rx_tick), .rx_en(rx_en), .rxs(rxs),
    .cfg_factor(cfg_factor), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .done(char_done), .brk_frame(brk_frame), .busy(busy),
    .frame_data(frame_data), .frame_perr(frame_perr), .frame_ferr(frame_ferr)
  );

  uart_rx_status u_stat (
    .clk(clk), .rst(rst), .done(char_done), .brk_frame(brk_frame),
    .frame_data(frame_data), .frame_perr(frame_perr), .frame_ferr(frame_ferr),
    .rxs(rxs), .rd_stb(rd_stb), .err_clr(err_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_frame(err_frame), .brk_det(brk_det)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic rd_stb,
  input logic err_clr,
  input logic char_done,
  input logic brk_frame,
  input logic busy,
  input logic rx_ready,
  input logic err_parity,
  input logic err_overrun,
  input logic err_frame,
  input logic brk_det
);
  // R7
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb && !char_done |=> !rx_ready);

  // R9
  pe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_parity) |-> $past(err_clr));

  // R9
  fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_frame) |-> $past(err_clr));

  // R9
  oe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(err_overrun) |-> $past(err_clr));

  // R6
  oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(char_done) && $past(rx_ready) && !$past(brk_frame));

  // R8
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_det) |-> $past(char_done) && $past(brk_frame));

  // R8
  brk_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    char_done && brk_frame && !rx_ready |=> !rx_ready);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !busy);
endmodule

bind uart_rx_ovs uart_rx_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_stb(rd_stb), .err_clr(err_clr),
  .char_done(char_done), .brk_frame(brk_frame), .busy(busy),
  .rx_ready(rx_ready), .err_parity(err_parity), .err_overrun(err_overrun),
  .err_frame(err_frame), .brk_det(brk_det)
);

// File: tb/tb_uart_rx_ovs.sv
`timescale 1ns/1ps
module tb_uart_rx_ovs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] cfg_factor = 2'b10;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_stb = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_overrun, err_frame, brk_det;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_rx_ovs dut (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_en(rx_en),
    .cfg_factor(cfg_factor), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .rxd(rxd), .rd_stb(rd_stb), .err_clr(err_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_frame(err_frame), .brk_det(brk_det)
  );

  // tick on every second cycle
  always @(negedge clk) rx_tick <= ~rx_tick;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   m_s1, m_s2, m_prev;
  int   m_ticks, m_phase, m_due;
  bit   q[$];
  bit   e_ready, e_pe, e_oe, e_fe, e_brk;
  logic [7:0] e_data;

  function automatic int ticks_per_bit(input logic [1:0] f);
    if (f == 2'b10) return 16;
    if (f == 2'b11) return 64;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_ticks = 0; m_phase = 0; m_due = 0;
      q.delete();
      e_ready = 0; e_pe = 0; e_oe = 0; e_fe = 0; e_brk = 0; e_data = 0;
    end else begin
      bit cur, fin, zeros, bad;
      int f, nb, val, ones;
      cur = m_s2; fin = 0;
      f = ticks_per_bit(cfg_factor);
      nb = 5 + int'(cfg_len);
      if (!rx_en) m_phase = 0;
      else if (rx_tick) begin
        if (m_phase == 0) begin
          if (m_prev && !cur) begin
            q.delete();
            if (f == 1) begin m_phase = 2; m_due = m_ticks + 1; end
            else begin m_phase = 1; m_due = m_ticks + f / 2; end
          end
        end else if (m_ticks == m_due) begin
          if (m_phase == 1) begin
            if (cur) m_phase = 0;
            else begin m_phase = 2; m_due = m_ticks + f; end
          end else begin
            q.push_back(cur);
            m_due = m_ticks + f;
            if (q.size() == nb + int'(cfg_par_en) + 1) begin fin = 1; m_phase = 0; end
          end
        end
      end
      if (rx_tick) begin m_prev = cur; m_ticks++; end
      if (err_clr) begin e_pe = 0; e_oe = 0; e_fe = 0; end
      if (fin) begin
        zeros = 1; val = 0; ones = 0;
        foreach (q[i]) if (q[i]) zeros = 0;
        for (int i = 0; i < nb; i++) begin val |= int'(q[i]) << i; ones += int'(q[i]); end
        if (zeros) begin
          e_fe = 1; e_brk = 1;
          if (rd_stb) e_ready = 0;
        end else begin
          if (e_ready && !rd_stb) e_oe = 1;
          e_ready = 1;
          e_data = val[7:0];
          if (cfg_par_en) begin
            ones += int'(q[nb]);
            bad = cfg_par_even ? (ones % 2 == 1) : (ones % 2 == 0);
            if (bad) e_pe = 1;
          end
          if (!q[q.size()-1]) e_fe = 1;
        end
      end else if (rd_stb) e_ready = 0;
      if (cur) e_brk = 0;
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (!rst) begin
    check("R7 rx_ready model", {31'b0, rx_ready}, {31'b0, e_ready});
    check("R3 rx_data model", {24'b0, rx_data}, {24'b0, e_data});
    check("R4 err_parity model", {31'b0, err_parity}, {31'b0, e_pe});
    check("R6 err_overrun model", {31'b0, err_overrun}, {31'b0, e_oe});
    check("R5 err_frame model", {31'b0, err_frame}, {31'b0, e_fe});
    check("R8 brk_det model", {31'b0, brk_det}, {31'b0, e_brk});
  end

  // ---------------- stimulus ----------------
  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input bit stop_lvl);
    int f, nb;
    bit p;
    f = ticks_per_bit(cfg_factor);
    nb = 5 + int'(cfg_len);
    rxd = 0; wait_ticks(f);
    p = 0;
    for (int i = 0; i < nb; i++) begin rxd = d[i]; p ^= d[i]; wait_ticks(f); end
    if (cfg_par_en) begin
      rxd = (cfg_par_even ? p : ~p) ^ flip_par;
      wait_ticks(f);
    end
    rxd = stop_lvl; wait_ticks(f);
    rxd = 1; wait_ticks(2 * f + 4);
  endtask

  task automatic pulse_rd();
    rd_stb = 1; @(negedge clk); rd_stb = 0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R7 reset state
    check("R7 reset ready", {31'b0, rx_ready}, 0);
    check("R7 reset flags", {29'b0, err_parity, err_overrun, err_frame}, 0);
    check("R8 reset brk", {31'b0, brk_det}, 0);
    check("R7 reset data", {24'b0, rx_data}, 0);
    rx_en = 1;
    wait_ticks(4);

    // R1 R2 R3: x16, 8 data bits, no parity
    cfg_factor = 2'b10; cfg_len = 2'd3; cfg_par_en = 0;
    send(8'hA5, 0, 1);
    check("R1 R2 x16 ready", {31'b0, rx_ready}, 1);
    check("R3 x16 8-bit data", {24'b0, rx_data}, 32'hA5);
    pulse_rd();
    check("R7 read clears ready", {31'b0, rx_ready}, 0);

    // R3 R4: 5 bits even parity
    cfg_len = 2'd0; cfg_par_en = 1; cfg_par_even = 1;
    send(8'hF3, 0, 1);
    check("R3 5-bit right-justified", {24'b0, rx_data}, 32'h13);
    check("R4 even parity ok", {31'b0, err_parity}, 0);
    pulse_rd();

    // R1 R2 R4: x64, 7 bits odd parity
    cfg_factor = 2'b11; cfg_len = 2'd2; cfg_par_even = 0;
    send(8'h5A, 0, 1);
    check("R1 x64 7-bit data", {24'b0, rx_data}, 32'h5A);
    check("R4 odd parity ok", {31'b0, err_parity}, 0);
    pulse_rd();

    // R2: x1, 8 bits no parity
    cfg_factor = 2'b01; cfg_len = 2'd3; cfg_par_en = 0;
    wait_ticks(4);
    send(8'h3C, 0, 1);
    check("R2 x1 data", {24'b0, rx_data}, 32'h3C);
    check("R2 x1 ready", {31'b0, rx_ready}, 1);
    pulse_rd();

    // R4 R9: parity error, sticky, cleared by err_clr
    cfg_factor = 2'b10; cfg_par_en = 1; cfg_par_even = 1;
    wait_ticks(40);
    send(8'h81, 1, 1);
    check("R4 parity mismatch", {31'b0, err_parity}, 1);
    pulse_rd();
    send(8'h22, 0, 1);
    check("R9 parity flag sticky", {31'b0, err_parity}, 1);
    pulse_clr();
    check("R9 err_clr clears parity", {31'b0, err_parity}, 0);
    pulse_rd();

    // R1: short start pulse rejected
    cfg_par_en = 0;
    rxd = 0; wait_ticks(4); rxd = 1; wait_ticks(300);
    check("R1 glitch rejected", {31'b0, rx_ready}, 0);

    // R5: low stop bit
    send(8'h55, 0, 0);
    check("R5 framing error", {31'b0, err_frame}, 1);
    check("R5 data still delivered", {24'b0, rx_data}, 32'h55);
    pulse_rd();
    pulse_clr();
    check("R9 err_clr clears frame", {31'b0, err_frame}, 0);

    // R6: overrun
    send(8'h11, 0, 1);
    send(8'h77, 0, 1);
    check("R6 overrun flag", {31'b0, err_overrun}, 1);
    check("R6 newer char kept", {24'b0, rx_data}, 32'h77);
    pulse_rd();
    pulse_clr();

    // R8: break frame
    rxd = 0; wait_ticks(16 * 11);
    check("R8 break detected", {31'b0, brk_det}, 1);
    check("R8 break sets frame error", {31'b0, err_frame}, 1);
    check("R8 break gives no char", {31'b0, rx_ready}, 0);
    check("R8 break keeps data", {24'b0, rx_data}, 32'h77);
    rxd = 1; wait_ticks(4);
    check("R8 break clears on high", {31'b0, brk_det}, 0);
    pulse_clr();
    wait_ticks(40);

    // R10: abort mid-frame
    rxd = 0; wait_ticks(16);
    rxd = 1; wait_ticks(24);
    rx_en = 0; wait_ticks(5);
    rx_en = 1; wait_ticks(200);
    check("R10 abort yields no char", {31'b0, rx_ready}, 0);
    send(8'hC3, 0, 1);
    check("R10 recovery data", {24'b0, rx_data}, 32'hC3);
    pulse_rd();
    wait_ticks(8);
    finish_run();
  end
endmodule